// File: doc/BRIEF.md
# Delay-Compensating Loop Predictor with Feedback Noise Cancellation

This block is the digital back-end of a closed-loop converter. The converter places a low-grade ADC behind an analog front filter and holds the ADC input near mid-scale through a feedback modulator. The block runs at the decimated (low) rate. Each accepted sample brings the decimated ADC word and the modulator bit stream averaged over the same period. From these the block produces two words. The first is a corrected conversion result. The second is a predicted feedback word for the modulator to reproduce during the next period.

The correction depends on a digital replica of the front filter and ADC path. This replica is driven by the feedback that was actually applied. Adding its output to the sign-restored ADC word removes the modulator's quantisation error from the result, and the sum is then scaled by a programmable attenuation. The predictor replaces a plain integrator with a fixed five-sample linear extrapolator. This offsets the delay of the direct path, so the loop bandwidth does not shrink. All coefficients are plain configuration inputs: model gain as a power-of-two shift, pole weight, reciprocal of one plus the pole weight, and output scale.

Top module: `loop_pred_backend`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first accepted sample, `result_o` and `pred_o` are 0 and `result_valid_o` is 0.
- R2: The ADC word arrives sign-inverted by the front filter and is negated before use. With a zero model state and `out_scale_i` = 32768, an ADC word of +1000 gives a result of -500.
- R3: The model updates once per accepted sample as m[n] = sat20(round((mod[n-1]·2^shift + α·m[n-1]) · recip / 2^16)). Here round(v/2^16) = floor((v + 2^15)/2^16), sat20 clamps to [-2^19, 2^19-1], and mod[n-1] is the averaged feedback word of the previous accepted sample (0 after reset).
- R4: result[n] = sat16(floor(((m[n] - adc[n])·out_scale + 2^15)/2^16)), with `out_scale_i` an unsigned Q0.16 fraction and sat16 clamping to [-32768, 32767]. It appears on `result_o` one clock after the accepting edge.
- R5: pred[n] = 2·result[n] - result[n-5], where result[n-5] comes from a five-entry delay line of previous results. It is updated together with `result_o`.
- R6: The predicted word saturates to [-32768, 32767] rather than wrapping.
- R7: Reset clears the delay line, so the first five predictions use 0 for result[n-5]. `result_valid_o` rises with the sixth accepted sample after reset and then stays high until the next reset.
- R8: A clock edge with `sample_valid_i` low changes no output and no internal state, whatever the other inputs carry.
- R9: `gain_shift_i` selects the model gain as 2^shift, so shift 3 doubles the feedback contribution of shift 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Strobe: one low-rate sample present |
| adc_word_i | input | 16 | Decimated ADC word, signed, sign-inverted by the front filter |
| mod_avg_i | input | 16 | Modulator stream averaged over the period, signed |
| gain_shift_i | input | 3 | Model gain exponent (G' = 2^shift) |
| alpha_i | input | 16 | Model pole weight, unsigned integer |
| recip_i | input | 16 | 1/(1+alpha) as an unsigned Q0.16 fraction |
| out_scale_i | input | 16 | Output attenuation as an unsigned Q0.16 fraction |
| pred_o | output | 16 | Predicted feedback word, signed, saturated |
| result_o | output | 16 | Corrected conversion result, signed |
| result_valid_o | output | 1 | Result valid once the delay line has filled |

## Verification
On every cycle the assertions check that idle edges leave the outputs and the model state untouched. They also check that the fill count never goes past the delay-line depth, and that the valid flag rises only on an accepted sample and then stays high. Only the bench scenarios can show the numerical parts: the sign restoration, the model recursion at each gain shift, the rounding and saturation of the scaled result, the extrapolation against the sample taken five periods earlier, and the zeroed taps after a reset in mid-stream.

// File: rtl/lpb_pkg.sv
package lpb_pkg;
  localparam int DATA_W  = 16;
  localparam int COEF_W  = 16;
  localparam int SHIFT_W = 3;
  localparam int FRAC_W  = 16;
  localparam int GUARD_W = 4;
  localparam int PRED_D  = 5;
endpackage

// File: rtl/lpb_model.sv
module lpb_model
  import lpb_pkg::*;
#(
  parameter int W    = DATA_W,
  parameter int MW   = DATA_W + GUARD_W,
  parameter int CW   = COEF_W,
  parameter int SW   = SHIFT_W,
  parameter int FRAC = FRAC_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strobe_i,
  input  logic signed [W-1:0]  fb_i,
  input  logic [SW-1:0]        shift_i,
  input  logic [CW-1:0]        alpha_i,
  input  logic [CW-1:0]        recip_i,
  output logic signed [MW-1:0] m_o
);
  localparam int ACC_W = MW + CW + 2;
  localparam int PW    = ACC_W + CW + 1;
  localparam logic signed [PW-1:0] RND  = PW'(longint'(1) << (FRAC - 1));
  localparam logic signed [PW-1:0] MAXV = PW'((longint'(1) << (MW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -PW'(longint'(1) << (MW - 1));

  logic signed [W-1:0]     fb_q;
  logic signed [MW-1:0]    m_q;
  logic signed [ACC_W-1:0] fb_ext, fb_sh, acc;
  logic signed [CW:0]      alpha_s, recip_s;
  logic signed [PW-1:0]    prod, rnd;
  logic signed [MW-1:0]    m_new;

  always_comb begin
    alpha_s = signed'({1'b0, alpha_i});
    recip_s = signed'({1'b0, recip_i});
    fb_ext  = ACC_W'(fb_q);
    fb_sh   = fb_ext <<< shift_i;
    acc     = fb_sh + alpha_s * m_q;
    prod    = acc * recip_s;
    rnd     = (prod + RND) >>> FRAC;
    if (rnd > MAXV)      m_new = MW'(MAXV);
    else if (rnd < MINV) m_new = MW'(MINV);
    else                 m_new = MW'(rnd);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_q <= '0;
      m_q  <= '0;
    end else if (strobe_i) begin
      fb_q <= fb_i;
      m_q  <= m_new;
    end
  end

  assign m_o = m_new;

  // R8: state only moves on accepted samples
  assert_model_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(m_q) && $stable(fb_q));
endmodule

// File: rtl/lpb_combine.sv
module lpb_combine
  import lpb_pkg::*;
#(
  parameter int W      = DATA_W,
  parameter int MW     = DATA_W + GUARD_W,
  parameter int CW     = COEF_W,
  parameter int FRAC   = FRAC_W,
  parameter bit INVERT = 1'b1
) (
  input  logic signed [W-1:0]  adc_i,
  input  logic signed [MW-1:0] m_i,
  input  logic [CW-1:0]        scale_i,
  output logic signed [W-1:0]  r_o
);
  localparam int SUM_W = MW + 1;
  localparam int VW    = SUM_W + CW + 1;
  localparam logic signed [VW-1:0] RND  = VW'(longint'(1) << (FRAC - 1));
  localparam logic signed [VW-1:0] MAXV = VW'((longint'(1) << (W - 1)) - 1);
  localparam logic signed [VW-1:0] MINV = -VW'(longint'(1) << (W - 1));

  logic signed [SUM_W-1:0] adc_n, sum;
  logic signed [CW:0]      scale_s;
  logic signed [VW-1:0]    prod, rnd;

  generate
    if (INVERT) begin : g_inv
      assign adc_n = -SUM_W'(adc_i);
    end else begin : g_pass
      assign adc_n = SUM_W'(adc_i);
    end
  endgenerate

  always_comb begin
    scale_s = signed'({1'b0, scale_i});
    sum     = SUM_W'(m_i) + adc_n;
    prod    = sum * scale_s;
    rnd     = (prod + RND) >>> FRAC;
    if (rnd > MAXV)      r_o = W'(MAXV);
    else if (rnd < MINV) r_o = W'(MINV);
    else                 r_o = W'(rnd);
  end
endmodule

// File: rtl/lpb_predictor.sv
module lpb_predictor
  import lpb_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int DEPTH = PRED_D
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_i,
  input  logic signed [W-1:0] r_i,
  output logic signed [W-1:0] result_o,
  output logic signed [W-1:0] pred_o,
  output logic                valid_o
);
  localparam int EW  = W + 2;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic signed [EW-1:0] MAXV = EW'((longint'(1) << (W - 1)) - 1);
  localparam logic signed [EW-1:0] MINV = -EW'(longint'(1) << (W - 1));

  logic signed [W-1:0]  tap_q [DEPTH];
  logic [CNT_W-1:0]     fill_q;
  logic signed [W-1:0]  result_q, pred_q;
  logic                 valid_q;
  logic signed [EW-1:0] extrap;
  logic signed [W-1:0]  pred_sat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tap_q[0] <= '0;
    else if (strobe_i) tap_q[0] <= r_i;
  end

  generate
    for (genvar i = 1; i < DEPTH; i++) begin : g_tap
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       tap_q[i] <= '0;
        else if (strobe_i) tap_q[i] <= tap_q[i-1];
      end
    end
  endgenerate

  always_comb begin
    extrap = (EW'(r_i) <<< 1) - EW'(tap_q[DEPTH-1]);
    if (extrap > MAXV)      pred_sat = W'(MAXV);
    else if (extrap < MINV) pred_sat = W'(MINV);
    else                    pred_sat = W'(extrap);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q   <= '0;
      result_q <= '0;
      pred_q   <= '0;
      valid_q  <= 1'b0;
    end else if (strobe_i) begin
      if (fill_q != FULL) fill_q <= fill_q + 1'b1;
      result_q <= r_i;
      pred_q   <= pred_sat;
      valid_q  <= (fill_q == FULL);
    end
  end

  assign result_o = result_q;
  assign pred_o   = pred_q;
  assign valid_o  = valid_q;

  assert_fill_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FULL);
  assert_valid_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> valid_q);
  assert_valid_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(strobe_i));
endmodule

// File: rtl/loop_pred_backend.sv
module loop_pred_backend
  import lpb_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int CW    = COEF_W,
  parameter int SW    = SHIFT_W,
  parameter int DEPTH = PRED_D
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_valid_i,
  input  logic signed [W-1:0] adc_word_i,
  input  logic signed [W-1:0] mod_avg_i,
  input  logic [SW-1:0]       gain_shift_i,
  input  logic [CW-1:0]       alpha_i,
  input  logic [CW-1:0]       recip_i,
  input  logic [CW-1:0]       out_scale_i,
  output logic signed [W-1:0] pred_o,
  output logic signed [W-1:0] result_o,
  output logic                result_valid_o
);
  localparam int MW = W + GUARD_W;

  logic signed [MW-1:0] model_w;
  logic signed [W-1:0]  corr_w;

  lpb_model #(.W(W), .MW(MW), .CW(CW), .SW(SW), .FRAC(FRAC_W)) u_model (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (sample_valid_i),
    .fb_i     (mod_avg_i),
    .shift_i  (gain_shift_i),
    .alpha_i  (alpha_i),
    .recip_i  (recip_i),
    .m_o      (model_w)
  );

  lpb_combine #(.W(W), .MW(MW), .CW(CW), .FRAC(FRAC_W), .INVERT(1'b1)) u_comb (
    .adc_i   (adc_word_i),
    .m_i     (model_w),
    .scale_i (out_scale_i),
    .r_o     (corr_w)
  );

  lpb_predictor #(.W(W), .DEPTH(DEPTH)) u_pred (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (sample_valid_i),
    .r_i      (corr_w),
    .result_o (result_o),
    .pred_o   (pred_o),
    .valid_o  (result_valid_o)
  );

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> $stable(result_o) && $stable(pred_o) && $stable(result_valid_o));
endmodule

// File: tb/sim_loop_pred_backend.sv
module sim_loop_pred_backend;
  localparam time CLK_PERIOD = 10ns;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               sv = 1'b0;
  logic signed [15:0] adc = '0, modv = '0;
  logic [2:0]         shift = 3'd2;
  logic [15:0]        alpha = 16'd40, recip = 16'd1598, scale = 16'd16384;
  logic signed [15:0] pred, res;
  logic               vld;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  longint y_ref, x_ref, fill_ref;
  longint line_ref [5];
  longint last_r;
  int unsigned lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_pred_backend u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(sv),
    .adc_word_i(adc), .mod_avg_i(modv), .gain_shift_i(shift),
    .alpha_i(alpha), .recip_i(recip), .out_scale_i(scale),
    .pred_o(pred), .result_o(res), .result_valid_o(vld)
  );

  function automatic longint rnd16(longint v);
    return (v + 32768) >>> 16;
  endfunction

  function automatic longint sat(longint v, longint lo, longint hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic int nextv(int span);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'(lcg >> 8) % (2 * span + 1) - span;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ref_clear();
    y_ref = 0; x_ref = 0; fill_ref = 0; last_r = 0;
    for (int i = 0; i < 5; i++) line_ref[i] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sv = 1'b0;
    ref_clear();
    repeat (2) @(negedge clk);
    check("R1 result in reset", longint'(res), 0);
    check("R1 pred in reset", longint'(pred), 0);
    check("R1 valid in reset", longint'(vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic step(int a, int m, string rtag);
    longint y, s, r, p, v;
    y = sat(rnd16(((longint'(x_ref) <<< shift) + longint'(alpha) * y_ref) * longint'(recip)),
            -524288, 524287);
    s = y - a;
    r = sat(rnd16(s * longint'(scale)), -32768, 32767);
    p = sat(2 * r - line_ref[4], -32768, 32767);
    v = (fill_ref == 5) ? 1 : 0;
    y_ref = y; x_ref = m;
    for (int i = 4; i > 0; i--) line_ref[i] = line_ref[i-1];
    line_ref[0] = r;
    if (fill_ref < 5) fill_ref++;
    last_r = r;
    adc = 16'(a); modv = 16'(m); sv = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sv = 1'b0;
    check(rtag, longint'(res), r);
    check("R5 pred", longint'(pred), p);
    check("R7 valid", longint'(vld), v);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 result after release", longint'(res), 0);
    check("R1 valid after release", longint'(vld), 0);
  endtask

  task automatic t_sign();
    do_reset();
    scale = 16'd32768;
    step(1000, 0, "R2 sign pos");
    check("R2 result -500", longint'(res), -500);
    step(-1000, 0, "R2 sign neg");
    check("R2 result 500", longint'(res), 500);
    scale = 16'd16384;
  endtask

  task automatic t_fill();
    do_reset();
    for (int i = 0; i < 7; i++) begin
      step(100 * (i + 1), 50 * i, "R4 fill");
      check("R7 valid timing", longint'(vld), (i >= 5) ? 1 : 0);
    end
  endtask

  task automatic t_model(int sh);
    do_reset();
    shift = 3'(sh);
    for (int i = 0; i < 40; i++) step(0, 4000, (sh == 3) ? "R9 gain shift" : "R3 model");
    shift = 3'd2;
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 200; i++) begin
      if (i == 100) begin alpha = 16'd20; recip = 16'd3121; scale = 16'd20000; end
      step(nextv(20000), nextv(30000), "R4 random");
    end
    alpha = 16'd40; recip = 16'd1598; scale = 16'd16384;
  endtask

  task automatic t_sat();
    do_reset();
    scale = 16'd65535;
    step(-32768, 0, "R4 sat high");
    check("R4 clamp high", longint'(res), 32767);
    check("R6 pred clamp high", longint'(pred), 32767);
    step(32767, 0, "R4 sat low");
    check("R6 pred clamp low", longint'(pred), -32768);
    for (int i = 0; i < 6; i++) step((i % 2) ? 32767 : -32768, 32767, "R4 sat seq");
    scale = 16'd16384;
  endtask

  task automatic t_hold();
    longint r0, p0, v0;
    do_reset();
    for (int i = 0; i < 8; i++) step(300 * i - 1000, 2000 - 100 * i, "R4 pre-hold");
    r0 = longint'(res); p0 = longint'(pred); v0 = longint'(vld);
    adc = 16'sd12345; modv = -16'sd23456; sv = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 result held", longint'(res), r0);
    check("R8 pred held", longint'(pred), p0);
    check("R8 valid held", longint'(vld), v0);
    for (int i = 0; i < 4; i++) step(500, -700, "R8 state held");
  endtask

  task automatic t_midreset();
    do_reset();
    for (int i = 0; i < 9; i++) step(2000 + i, 1000, "R4 pre-reset");
    do_reset();
    step(-3000, 0, "R7 post-reset result");
    check("R7 cleared tap", longint'(pred), sat(2 * last_r, -32768, 32767));
  endtask

  initial begin
    ref_clear();
    t_reset();
    t_sign();
    t_fill();
    t_model(2);
    t_model(3);
    t_random();
    t_sat();
    t_hold();
    t_midreset();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule